// File: doc/BRIEF.md
# Dual Interval Timer With Interrupt Controller

The block holds two 16-bit down-counters behind a byte-wide register window, plus a flag/enable pair that drives one active-high interrupt line. The first counter reloads from a 16-bit latch and can run either free or one-shot. The second counter is always one-shot and takes its low byte from an 8-bit holding register. Both counters step only on cycles where the prescaler enable `tick_en` is high. This lets the surrounding logic pick the count rate without a second clock.

A counter goes from its start value down through zero to all-ones. The step from zero to all-ones is the expiry, and it raises that counter's flag. In free-running mode, the first counter goes from all-ones back to its latch value on the next tick, so one period takes latch+2 ticks. Software arms a counter by writing a high byte. It services a flag either by reading the counter's low byte or by writing a one to the flag bit. A third flag is set by the external `xfer_done` pulse. The interrupt line follows the first-counter flag and the transfer flag, each gated by its enable. The second-counter flag is visible in the flag register but never drives the line.

Top module: `dual_timer_irq`

## Requirements
- R1: Each counter decrements by one, modulo 2^16, on every clock with `tick_en` high, and holds its value when `tick_en` is low.
- R2: When mode register (index 6) bits [7:6] equal 2'b01, counter 1 goes from 0xFFFF to its latch on the next tick. Its period is latch+2 ticks, and flag bit 6 is set at every pass from 0 to 0xFFFF.
- R3: With any other mode value, counter 1 sets flag bit 6 only at the first 0-to-0xFFFF pass after a load. It then keeps decrementing without raising the flag again.
- R4: A write to index 1 sets latch bits [15:8] and loads the counter with {data, latch[7:0]}. The load takes priority over a tick in the same cycle. The write also clears flag bit 6.
- R5: A write to index 0 or index 2 changes only latch bits [7:0]. The counter is not affected. Index 2 and index 3 read back the latch low and high bytes.
- R6: A write to index 3 sets latch bits [15:8] and clears flag bit 6. The counter is left unchanged.
- R7: A write to index 4 stores an 8-bit holding value. A write to index 5 loads counter 2 with {data, holding}. Counter 2 sets flag bit 5 once, at its first 0-to-0xFFFF pass after that load.
- R8: A write to the enable register (index 8) with bit 7 set ORs bits [6:0] into the enables. With bit 7 clear, it clears the enables selected by bits [6:0]. A read returns {0, enables}.
- R9: The `irq` output is registered. One clock after the flags and enables share a set bit in position 6 or 2, `irq` is high. Flag bit 5 never raises `irq`.
- R10: After reset, counter 1, latch 1 and counter 2 read 0xFFFF, the counter 2 holding value is 0, and the flags, enables and `irq` are 0.
- R11: A read of index 0 clears flag bit 6. A read of index 4 clears flag bit 5. A read of the flag register (index 7) returns flags in [6:0] and, in bit 7, whether any enabled flag is set. A write to index 7 clears each flag whose data bit is 1.
- R12: When a flag is set and cleared in the same cycle, whether by a read, a write-one or a latch write, the set wins.
- R13: A one-cycle pulse on `xfer_done` sets flag bit 2.
- R14: Register reads are registered. `rdata` shows the addressed value one clock after the cycle in which `cs` and `rd` are high, and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Prescaler enable; counters step on cycles where it is high |
| cs | input | 1 | Chip select for the register window |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 4 | Register index |
| wdata | input | 8 | Write data |
| xfer_done | input | 1 | Pulse that sets the transfer flag |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
Flag setting by a counter expiry or an `xfer_done` pulse can fall in the same cycle as a flag clear. The clear can come from a low-byte read, a write-one to the flag register or a latch-high write. The bench loads counter 1 with zero and raises `tick_en` in the same cycle as one of these clearing accesses, so the expiry and the clear land on the same edge. It then reads the flag register and expects the flag to be set and the counter to read 0xFFFF. It provokes the transfer flag the same way by pulsing `xfer_done` together with a write-one clear.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
  // register indices on the byte bus
  localparam logic [3:0] RI_T1_CLO  = 4'd0;
  localparam logic [3:0] RI_T1_CHI  = 4'd1;
  localparam logic [3:0] RI_T1_LLO  = 4'd2;
  localparam logic [3:0] RI_T1_LHI  = 4'd3;
  localparam logic [3:0] RI_T2_LO   = 4'd4;
  localparam logic [3:0] RI_T2_HI   = 4'd5;
  localparam logic [3:0] RI_MODE    = 4'd6;
  localparam logic [3:0] RI_FLAGS   = 4'd7;
  localparam logic [3:0] RI_ENABLE  = 4'd8;
  // flag bit positions
  localparam int FLG_T1   = 6;
  localparam int FLG_T2   = 5;
  localparam int FLG_XFER = 2;
  // mode field value selecting free-running counter 1
  localparam logic [1:0] T1_FREE = 2'b01;
endpackage

// File: rtl/dtm_counter.sv
module dtm_counter #(
  parameter int W          = 16,
  parameter bit HAS_RELOAD = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         free_run,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] count,
  output logic         fire
);
  logic armed;
  logic run_free;
  logic [W-1:0] next_val;

  generate
    if (HAS_RELOAD) begin : g_reload
      assign run_free = free_run;
      assign next_val = (count == '1 && run_free) ? reload_val : count - 1'b1;
    end else begin : g_oneshot
      logic unused_in;
      assign unused_in = ^{free_run, reload_val};
      assign run_free  = 1'b0;
      assign next_val  = count - 1'b1;
    end
  endgenerate

  // expiry: passing from zero to all-ones while armed or free-running
  assign fire = tick && !load && (count == '0) && (armed || run_free);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '1;
      armed <= 1'b0;
    end else if (load) begin
      count <= load_val;
      armed <= 1'b1;
    end else if (tick) begin
      count <= next_val;
      if (fire && !run_free) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/dtm_irq.sv
module dtm_irq #(
  parameter int           NF       = 7,
  parameter logic [NF-1:0] IRQ_MASK = 7'h44
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set_vec,
  input  logic [NF-1:0] clr_vec,
  input  logic          en_wr,
  input  logic [NF:0]   en_data,
  output logic [NF-1:0] flags,
  output logic [NF-1:0] enables,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags   <= '0;
      enables <= '0;
      irq     <= 1'b0;
    end else begin
      flags <= (flags & ~clr_vec) | set_vec;
      if (en_wr) begin
        if (en_data[NF]) enables <= enables | en_data[NF-1:0];
        else             enables <= enables & ~en_data[NF-1:0];
      end
      irq <= |(flags & enables & IRQ_MASK);
    end
  end
endmodule

// File: rtl/dual_timer_irq.sv
module dual_timer_irq
  import dtm_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [IDX_W-1:0]  addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              xfer_done,
  output logic [BYTE_W-1:0] rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * BYTE_W;
  localparam int NF    = BYTE_W - 1;

  logic              wr_hit, rd_hit;
  logic [CNT_W-1:0]  t1_latch, t1_cnt, t2_cnt;
  logic [BYTE_W-1:0] t2_hold, mode_q;
  logic              t1_load, t2_load, t1_fire, t2_fire, t1_free;
  logic [NF-1:0]     set_vec, clr_vec, flags, enables;
  logic [BYTE_W-1:0] rd_mux;

  assign wr_hit  = cs && wr;
  assign rd_hit  = cs && rd;
  assign t1_load = wr_hit && (addr == IDX_W'(RI_T1_CHI));
  assign t2_load = wr_hit && (addr == IDX_W'(RI_T2_HI));
  assign t1_free = (mode_q[BYTE_W-1 -: 2] == T1_FREE);

  always_ff @(posedge clk) begin
    if (rst) begin
      t1_latch <= '1;
      t2_hold  <= '0;
      mode_q   <= '0;
    end else if (wr_hit) begin
      case (addr)
        IDX_W'(RI_T1_CLO), IDX_W'(RI_T1_LLO): t1_latch[BYTE_W-1:0] <= wdata;
        IDX_W'(RI_T1_CHI), IDX_W'(RI_T1_LHI): t1_latch[CNT_W-1:BYTE_W] <= wdata;
        IDX_W'(RI_T2_LO):                     t2_hold <= wdata;
        IDX_W'(RI_MODE):                      mode_q  <= wdata;
        default: ;
      endcase
    end
  end

  dtm_counter #(.W(CNT_W), .HAS_RELOAD(1'b1)) u_t1 (
    .clk(clk), .rst(rst), .tick(tick_en), .load(t1_load),
    .load_val({wdata, t1_latch[BYTE_W-1:0]}), .free_run(t1_free),
    .reload_val(t1_latch), .count(t1_cnt), .fire(t1_fire));

  dtm_counter #(.W(CNT_W), .HAS_RELOAD(1'b0)) u_t2 (
    .clk(clk), .rst(rst), .tick(tick_en), .load(t2_load),
    .load_val({wdata, t2_hold}), .free_run(1'b0),
    .reload_val('0), .count(t2_cnt), .fire(t2_fire));

  always_comb begin
    set_vec = '0;
    set_vec[FLG_T1]   = t1_fire;
    set_vec[FLG_T2]   = t2_fire;
    set_vec[FLG_XFER] = xfer_done;
    clr_vec = (wr_hit && addr == IDX_W'(RI_FLAGS)) ? wdata[NF-1:0] : '0;
    if ((wr_hit && (addr == IDX_W'(RI_T1_CHI) || addr == IDX_W'(RI_T1_LHI))) ||
        (rd_hit && addr == IDX_W'(RI_T1_CLO)))
      clr_vec[FLG_T1] = 1'b1;
    if (rd_hit && addr == IDX_W'(RI_T2_LO))
      clr_vec[FLG_T2] = 1'b1;
  end

  dtm_irq #(.NF(NF), .IRQ_MASK(NF'((1 << FLG_T1) | (1 << FLG_XFER)))) u_irq (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec),
    .en_wr(wr_hit && addr == IDX_W'(RI_ENABLE)), .en_data(wdata),
    .flags(flags), .enables(enables), .irq(irq));

  always_comb begin
    case (addr)
      IDX_W'(RI_T1_CLO): rd_mux = t1_cnt[BYTE_W-1:0];
      IDX_W'(RI_T1_CHI): rd_mux = t1_cnt[CNT_W-1:BYTE_W];
      IDX_W'(RI_T1_LLO): rd_mux = t1_latch[BYTE_W-1:0];
      IDX_W'(RI_T1_LHI): rd_mux = t1_latch[CNT_W-1:BYTE_W];
      IDX_W'(RI_T2_LO):  rd_mux = t2_cnt[BYTE_W-1:0];
      IDX_W'(RI_T2_HI):  rd_mux = t2_cnt[CNT_W-1:BYTE_W];
      IDX_W'(RI_MODE):   rd_mux = mode_q;
      IDX_W'(RI_FLAGS):  rd_mux = {|(flags & enables), flags};
      IDX_W'(RI_ENABLE): rd_mux = {1'b0, enables};
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_hit) rdata <= rd_mux;
  end
endmodule

// File: rtl/dtm_checker.sv
module dtm_checker #(
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                tick_en,
  input logic                cs,
  input logic                wr,
  input logic [IDX_W-1:0]    addr,
  input logic [BYTE_W-1:0]   wdata,
  input logic                irq,
  input logic [2*BYTE_W-1:0] t1_cnt,
  input logic [2*BYTE_W-1:0] t1_latch,
  input logic [BYTE_W-1:0]   mode_q,
  input logic [BYTE_W-2:0]   flags,
  input logic [BYTE_W-2:0]   enables
);
  localparam int CW = 2 * BYTE_W;
  logic ld1, free1;
  assign ld1   = cs && wr && (addr == IDX_W'(1));
  assign free1 = (mode_q[BYTE_W-1 -: 2] == 2'b01);

  AST_T1_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !ld1 && !(free1 && t1_cnt == '1)) |=> t1_cnt == CW'($past(t1_cnt) - 1'b1)); // R1
  AST_T1_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !ld1) |=> $stable(t1_cnt)); // R1
  AST_T1_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !ld1 && free1 && t1_cnt == '1) |=> t1_cnt == $past(t1_latch)); // R2
  AST_T1_LOAD: assert property (@(posedge clk) disable iff (rst)
    ld1 |=> (t1_cnt == {$past(wdata), $past(t1_latch[BYTE_W-1:0])}) && !flags[6]); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !ld1 && free1 && t1_cnt == '0) |=> flags[6]); // R12
  AST_NO_SPURIOUS_IRQ: assert property (@(posedge clk) disable iff (rst)
    (!(flags[6] && enables[6]) && !(flags[2] && enables[2])) |=> !irq); // R9
  AST_ENABLE_SET: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && addr == IDX_W'(8) && wdata[BYTE_W-1])
      |=> (enables & $past(wdata[BYTE_W-2:0])) == $past(wdata[BYTE_W-2:0])); // R8
endmodule

bind dual_timer_irq dtm_checker #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .cs(cs), .wr(wr), .addr(addr),
  .wdata(wdata), .irq(irq), .t1_cnt(t1_cnt), .t1_latch(t1_latch),
  .mode_q(mode_q), .flags(flags), .enables(enables));

// File: tb/tb_dual_timer_irq.sv
module tb_dual_timer_irq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0, cs = 1'b0, rd = 1'b0, wr = 1'b0, xfer_done = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_timer_irq dut (.clk(clk), .rst(rst), .tick_en(tick_en), .cs(cs), .rd(rd),
    .wr(wr), .addr(addr), .wdata(wdata), .xfer_done(xfer_done), .rdata(rdata), .irq(irq));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; rd = 1; addr = a;
    @(negedge clk); d = rdata; cs = 0; rd = 0;
  endtask

  task automatic tick(input int n);
    @(negedge clk); tick_en = 1;
    repeat (n) @(negedge clk);
    tick_en = 0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    bus_rd(a, v);
    check(tag, {8'h00, v}, {8'h00, exp});
  endtask

  function automatic logic [15:0] exp_cnt(int L, int d, bit free);
    if (!free || d <= L + 1) return 16'(L - d);
    return 16'(L - ((d - L - 2) % (L + 2)));
  endfunction

  function automatic bit exp_fire(int L, int d, bit free);
    if (free) return (d >= L + 1) && ((d - L - 1) % (L + 2) == 0);
    return d == L + 1;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state
    check("R10 irq", {15'd0, irq}, 16'd0);
    rd_chk(4'd0, 8'hFF, "R10 t1 cnt lo");
    rd_chk(4'd1, 8'hFF, "R10 t1 cnt hi");
    rd_chk(4'd2, 8'hFF, "R10 t1 latch lo");
    rd_chk(4'd3, 8'hFF, "R10 t1 latch hi");
    rd_chk(4'd4, 8'hFF, "R10 t2 cnt lo");
    rd_chk(4'd5, 8'hFF, "R10 t2 cnt hi");
    rd_chk(4'd7, 8'h00, "R10 flags");
    rd_chk(4'd8, 8'h00, "R10 enables");
    bus_wr(4'd5, 8'h12);
    rd_chk(4'd4, 8'h00, "R10 t2 holding zero");
    rd_chk(4'd5, 8'h12, "R10 R7 t2 load hi");

    // R1 R2 R3 R11: tick-by-tick sweep in both modes
    for (int m = 0; m < 2; m++) begin
      bus_wr(4'd6, m ? 8'h40 : 8'hC0);
      for (int li = 0; li < 5; li++) begin
        int L;
        L = (li == 4) ? 7 : li;
        bus_wr(4'd2, 8'(L));
        bus_wr(4'd1, 8'(L >> 8));
        for (int d = 1; d <= 3 * L + 6; d++) begin
          logic [7:0] hi, lo;
          logic [15:0] e;
          tick(1);
          e = exp_cnt(L, d, m[0]);
          bus_rd(4'd7, v);
          check(m ? "R2 free flag" : "R3 one-shot flag", {8'h00, v},
                exp_fire(L, d, m[0]) ? 16'h0040 : 16'h0000);
          bus_rd(4'd1, hi);
          bus_rd(4'd0, lo);   // R11: clears flag bit 6
          check(m ? "R1 R2 free count" : "R1 R3 one-shot count", {hi, lo}, e);
        end
      end
    end
    rd_chk(4'd7, 8'h00, "R11 low-byte read cleared flag");

    // R5 R6 R4 latch and load paths
    bus_wr(4'd6, 8'h00);
    bus_wr(4'd2, 8'h00);
    bus_wr(4'd1, 8'h00);
    tick(1);
    rd_chk(4'd7, 8'h40, "R3 flag after expiry");
    bus_wr(4'd0, 8'h56);
    bus_wr(4'd3, 8'h78);
    rd_chk(4'd7, 8'h00, "R6 latch-high write clears flag");
    rd_chk(4'd1, 8'hFF, "R5 R6 counter untouched hi");
    rd_chk(4'd0, 8'hFF, "R5 R6 counter untouched lo");
    rd_chk(4'd2, 8'h56, "R5 latch lo via index 0");
    bus_wr(4'd2, 8'h34);
    rd_chk(4'd2, 8'h34, "R5 latch lo via index 2");
    rd_chk(4'd3, 8'h78, "R6 latch hi");
    bus_wr(4'd1, 8'h9A);
    rd_chk(4'd1, 8'h9A, "R4 load hi");
    rd_chk(4'd0, 8'h34, "R4 load lo");
    rd_chk(4'd3, 8'h9A, "R4 latch hi updated");
    tick(5);
    rd_chk(4'd0, 8'h2F, "R1 five ticks");
    repeat (4) @(negedge clk);
    rd_chk(4'd0, 8'h2F, "R1 hold without tick");

    // R12 expiry and read-clear on the same edge
    bus_wr(4'd2, 8'h00);
    bus_wr(4'd1, 8'h00);
    @(negedge clk); tick_en = 1; cs = 1; rd = 1; addr = 4'd0;
    @(negedge clk); tick_en = 0; cs = 0; rd = 0;
    check("R14 R12 read value before tick", {8'h00, rdata}, 16'h0000);
    rd_chk(4'd7, 8'h40, "R12 set beats read clear");
    rd_chk(4'd1, 8'hFF, "R12 counter wrapped");
    // expiry and write-one clear together
    bus_wr(4'd1, 8'h00);
    @(negedge clk); tick_en = 1; cs = 1; wr = 1; addr = 4'd7; wdata = 8'h40;
    @(negedge clk); tick_en = 0; cs = 0; wr = 0;
    rd_chk(4'd7, 8'h40, "R12 set beats write-one clear");
    bus_wr(4'd7, 8'h40);
    rd_chk(4'd7, 8'h00, "R11 write-one clear");

    // R13 with clear in the same cycle
    @(negedge clk); xfer_done = 1;
    @(negedge clk); xfer_done = 0;
    rd_chk(4'd7, 8'h04, "R13 transfer flag");
    @(negedge clk); xfer_done = 1; cs = 1; wr = 1; addr = 4'd7; wdata = 8'h04;
    @(negedge clk); xfer_done = 0; cs = 0; wr = 0;
    rd_chk(4'd7, 8'h04, "R12 R13 set beats clear");
    bus_wr(4'd7, 8'h04);

    // R8 enable set/clear
    bus_wr(4'd8, 8'hC4);
    rd_chk(4'd8, 8'h44, "R8 set bits");
    bus_wr(4'd8, 8'h04);
    rd_chk(4'd8, 8'h40, "R8 clear bit");
    bus_wr(4'd8, 8'hA0);
    rd_chk(4'd8, 8'h60, "R8 set more");
    bus_wr(4'd8, 8'h20);
    rd_chk(4'd8, 8'h40, "R8 clear again");

    // R9 interrupt line
    bus_wr(4'd2, 8'h01);
    bus_wr(4'd1, 8'h00);
    @(negedge clk); @(negedge clk);
    check("R9 idle irq", {15'd0, irq}, 16'd0);
    tick(2);
    @(negedge clk);
    check("R9 irq on enabled t1 flag", {15'd0, irq}, 16'd1);
    rd_chk(4'd7, 8'hC0, "R11 flag read bit 7");
    bus_wr(4'd7, 8'h40);
    @(negedge clk); @(negedge clk);
    check("R9 irq drops", {15'd0, irq}, 16'd0);
    @(negedge clk); xfer_done = 1;
    @(negedge clk); xfer_done = 0;
    @(negedge clk);
    check("R9 R13 transfer flag not enabled", {15'd0, irq}, 16'd0);
    bus_wr(4'd8, 8'h84);
    @(negedge clk); @(negedge clk);
    check("R9 transfer flag enabled", {15'd0, irq}, 16'd1);
    bus_wr(4'd7, 8'h04);
    bus_wr(4'd8, 8'h04);

    // R7 counter 2 one-shot, never drives irq
    bus_wr(4'd8, 8'hA0);
    bus_wr(4'd4, 8'h03);
    bus_wr(4'd5, 8'h00);
    tick(3);
    rd_chk(4'd7, 8'h00, "R7 t2 not yet");
    tick(1);
    @(negedge clk); @(negedge clk);
    check("R9 t2 flag no irq", {15'd0, irq}, 16'd0);
    rd_chk(4'd7, 8'hA0, "R7 R11 t2 flag with bit 7");
    rd_chk(4'd4, 8'hFF, "R7 t2 lo at wrap");
    rd_chk(4'd7, 8'h00, "R11 t2 low read clears");
    tick(20);
    rd_chk(4'd7, 8'h00, "R7 no second t2 flag");
    rd_chk(4'd5, 8'hFF, "R1 R7 t2 hi after 24");
    rd_chk(4'd4, 8'hEB, "R1 R7 t2 lo after 24");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule